// File: doc/BRIEF.md
# Flash Busy Status Bit Generator

This block produces the status that a parallel NOR flash returns on its data bus while an internal program or erase runs. It watches the host's combined write strobe and counts write pulses. A program command begins on its fourth pulse and an erase command begins on its sixth. A down-counter loaded from a parameter then stands in for the internal operation time. While that counter runs, reads return two status bits. Bit 7 is a data-polling flag. Bit 6 is a toggle flag that changes on every read.

When the counter expires, a one-cycle done pulse is raised and the bus returns to the array data supplied by the surrounding model. The command decoder that drives `op_erase` and `cmd_abort`, the array itself and the analog protection circuits are outside the block.

Top module: `flash_poll_status`

## Requirements
- R1: A write pulse is the cycle in which the combined strobe (`we_n` and `ce_n` both low) goes from active to inactive, seen on two successive clock edges. A strobe with only one of the two low is not counted.
- R2: While idle, a program starts on the 4th write pulse if `op_erase` is low at that pulse. An erase starts on the 6th pulse if `op_erase` is high at that pulse. In both cases the pulse count then returns to zero.
- R3: `cmd_abort` high in an idle cycle clears the pulse count, so a full sequence is needed again. It takes priority over a pulse in the same cycle.
- R4: `busy` rises in the cycle after the starting pulse. It stays high for exactly PGM_CYCLES cycles for a program and ERS_CYCLES cycles for an erase.
- R5: `done` is high for exactly one cycle: the first cycle in which `busy` is low again.
- R6: While a program is busy, `dq_out[7]` is the inverse of `wr_data_msb` as captured during the final write pulse.
- R7: While an erase is busy, `dq_out[7]` is 0.
- R8: `dq_out[6]` is 0 in the first busy cycle. It inverts in the cycle after each busy cycle with `rd_stb` high, and holds its value otherwise.
- R9: While busy, the bits of `dq_out` other than 7 and 6 are 0 when PASS_OTHERS is 0. They equal `array_data` when PASS_OTHERS is 1.
- R10: While not busy, `dq_out` equals `array_data`.
- R11: Write pulses during a busy phase are ignored. The count after completion is the same as before the operation started.
- R12: After reset, `busy`, `done` and the pulse count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Write enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| wr_data_msb | input | 1 | Bit 7 of the data on the bus during a write |
| op_erase | input | 1 | High when the pending command is an erase |
| cmd_abort | input | 1 | Clears the pulse count |
| rd_stb | input | 1 | One cycle per host read |
| array_data | input | DW | True array contents at the read address |
| busy | output | 1 | Internal operation running |
| done | output | 1 | One-cycle completion pulse |
| dq_out | output | DW | Data returned to the host |

## Verification
Programs are run with written bit 7 set and clear, which separates the inverted polling bit from a copied or constant one. Erases are run with read bursts and gaps, which shows that the toggle bit moves only on reads and not on every busy cycle. Some sequences are made short, aborted, mixed with one-sided strobes, or contain pulses during a busy phase. These show whether the pulse counter counts, clears and ignores exactly the cycles it should. Two instances, one for each PASS_OTHERS setting, check the low bits against zero and against array data.

// File: rtl/flash_poll_status.sv
module flash_poll_status #(
  parameter int DW          = 16,
  parameter int PGM_CYCLES  = 20,
  parameter int ERS_CYCLES  = 60,
  parameter bit PASS_OTHERS = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic          ce_n,
  input  logic          wr_data_msb,
  input  logic          op_erase,
  input  logic          cmd_abort,
  input  logic          rd_stb,
  input  logic [DW-1:0] array_data,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] dq_out
);
  localparam int MAXC = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic          wr_prev, msb_q, pol_q, ers_q, tgl_q, busy_q, done_q;
  logic [2:0]    pcnt;
  logic [CW-1:0] rem;
  logic          wr_act, wr_pulse, start;
  logic [2:0]    need;
  logic [DW-1:0] stat;

  assign wr_act   = ~we_n & ~ce_n;
  assign wr_pulse = wr_prev & ~wr_act;
  assign need     = op_erase ? 3'd6 : 3'd4;
  assign start    = ~busy_q & ~cmd_abort & wr_pulse & ((pcnt + 3'd1) == need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_prev <= 1'b0;
      msb_q   <= 1'b0;
      pol_q   <= 1'b0;
      ers_q   <= 1'b0;
      tgl_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pcnt    <= '0;
      rem     <= '0;
    end else begin
      wr_prev <= wr_act;
      if (wr_act) msb_q <= wr_data_msb;
      if (busy_q) begin
        if (rd_stb) tgl_q <= ~tgl_q;
        if (rem == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          rem    <= rem - 1'b1;
          done_q <= 1'b0;
        end
      end else begin
        done_q <= 1'b0;
        if (cmd_abort) begin
          pcnt <= '0;
        end else if (start) begin
          busy_q <= 1'b1;
          ers_q  <= op_erase;
          pol_q  <= ~msb_q;
          tgl_q  <= 1'b0;
          pcnt   <= '0;
          rem    <= op_erase ? CW'(ERS_CYCLES - 1) : CW'(PGM_CYCLES - 1);
        end else if (wr_pulse) begin
          pcnt <= pcnt + 3'd1;
        end
      end
    end
  end

  always_comb begin
    stat    = PASS_OTHERS ? array_data : '0;
    stat[7] = ~ers_q & pol_q;
    stat[6] = tgl_q;
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign dq_out = busy_q ? stat : array_data;
endmodule

// File: rtl/flash_poll_status_chk.sv
module flash_poll_status_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          rd_stb,
  input logic          op_ers,
  input logic [2:0]    pcnt,
  input logic [DW-1:0] array_data,
  input logic [DW-1:0] dq_out
);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R10
  idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dq_out == array_data);
  // R7
  erase_poll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_ers |-> !dq_out[7]);
  // R8
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(rd_stb) |-> $stable(dq_out[6]));
  // R8
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(rd_stb) |-> dq_out[6] != $past(dq_out[6]));
  // R2
  pulse_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= 3'd5);
endmodule

bind flash_poll_status flash_poll_status_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_stb(rd_stb),
  .op_ers(ers_q), .pcnt(pcnt), .array_data(array_data), .dq_out(dq_out)
);

// File: tb/flash_poll_status_test.sv
module flash_poll_status_test;
  localparam int DW = 16;
  localparam int PGM = 6;
  localparam int ERS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_n = 1'b1, ce_n = 1'b1, wr_data_msb = 1'b0, op_erase = 1'b0;
  logic cmd_abort = 1'b0, rd_stb = 1'b0;
  logic [DW-1:0] array_data = 16'h1234;
  logic busy, done, busy_b, done_b;
  logic [DW-1:0] dq_out, dq_b;
  int errs = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;

  flash_poll_status #(.DW(DW), .PGM_CYCLES(PGM), .ERS_CYCLES(ERS), .PASS_OTHERS(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .wr_data_msb(wr_data_msb),
    .op_erase(op_erase), .cmd_abort(cmd_abort), .rd_stb(rd_stb), .array_data(array_data),
    .busy(busy), .done(done), .dq_out(dq_out));

  flash_poll_status #(.DW(DW), .PGM_CYCLES(PGM), .ERS_CYCLES(ERS), .PASS_OTHERS(1'b1)) uut_b (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .wr_data_msb(wr_data_msb),
    .op_erase(op_erase), .cmd_abort(cmd_abort), .rd_stb(rd_stb), .array_data(array_data),
    .busy(busy_b), .done(done_b), .dq_out(dq_b));

  // behavioural reference
  bit m_prev, m_msb, m_data, m_ers, m_tgl, m_busy, m_done;
  int m_cnt, m_rem;

  always @(posedge clk) begin
    bit act, pls;
    int nd;
    if (!rst_n) begin
      m_prev = 0; m_msb = 0; m_data = 0; m_ers = 0; m_tgl = 0;
      m_busy = 0; m_done = 0; m_cnt = 0; m_rem = 0;
    end else begin
      act = !we_n && !ce_n;
      pls = m_prev && !act;
      m_prev = act;
      if (m_busy) begin
        if (rd_stb) m_tgl = !m_tgl;
        if (m_rem == 0) begin m_busy = 0; m_done = 1; end
        else begin m_rem--; m_done = 0; end
      end else begin
        m_done = 0;
        nd = op_erase ? 6 : 4;
        if (cmd_abort) m_cnt = 0;
        else if (pls) begin
          if (m_cnt + 1 == nd) begin
            m_busy = 1; m_ers = op_erase; m_data = m_msb; m_tgl = 0; m_cnt = 0;
            m_rem = (op_erase ? ERS : PGM) - 1;
          end else m_cnt++;
        end
      end
      if (act) m_msb = wr_data_msb;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [DW-1:0] e0, e1;
    if (m_busy) begin
      e0 = '0; e1 = array_data;
      e0[7] = m_ers ? 1'b0 : !m_data; e1[7] = e0[7];
      e0[6] = m_tgl; e1[6] = m_tgl;
    end else begin
      e0 = array_data; e1 = array_data;
    end
    chk(busy == m_busy && busy_b == m_busy, "R4 busy", {15'd0, busy}, {15'd0, m_busy});
    chk(done == m_done && done_b == m_done, "R5 done", {15'd0, done}, {15'd0, m_done});
    chk(dq_out[7] == e0[7] && dq_b[7] == e0[7],
        m_busy ? (m_ers ? "R7 dq7" : "R6 dq7") : "R10 dq7", dq_out, e0);
    chk(dq_out[6] == e0[6] && dq_b[6] == e0[6], m_busy ? "R8 dq6" : "R10 dq6", dq_out, e0);
    chk(dq_out == e0, m_busy ? "R9 low bits zero" : "R10 passthru", dq_out, e0);
    chk(dq_b == e1, m_busy ? "R9 low bits array" : "R10 passthru", dq_b, e1);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) compare();
    array_data = array_data * 16'd5 + 16'd7;
  endtask

  task automatic wpulse(input bit msb, input bit ers, input bit ce_only = 0);
    op_erase = ers; wr_data_msb = msb;
    we_n = ce_only; ce_n = 1'b0;
    cyc();
    we_n = 1'b1; ce_n = 1'b1;
    cyc();
  endtask

  task automatic rd(input int n);
    for (int i = 0; i < n; i++) begin rd_stb = 1'b1; cyc(); end
    rd_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wait_done();
    for (int i = 0; i < 100 && busy; i++) cyc();
    cyc();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    chk(!busy && !done, "R12 reset", {14'd0, busy, done}, '0);
    // R6 program, msb 1 -> polling 0
    for (int i = 0; i < 4; i++) wpulse(1, 0);
    chk(busy, "R2 program start", {15'd0, busy}, 16'd1);
    rd(3); idle(1); rd(1);
    wait_done();
    // R6 program, msb 0 -> polling 1
    for (int i = 0; i < 4; i++) wpulse(i != 3 ? 1'b1 : 1'b0, 0);
    rd(2); wait_done();
    // R7 erase with reads and gaps
    for (int i = 0; i < 6; i++) wpulse(1, 1);
    rd(1); idle(2); rd(4); idle(1); rd(1);
    wait_done();
    // R2 four pulses with erase selected do not start
    for (int i = 0; i < 4; i++) wpulse(0, 1);
    chk(!busy, "R2 erase needs six", {15'd0, busy}, 16'd0);
    for (int i = 0; i < 2; i++) wpulse(0, 1);
    chk(busy, "R2 erase start", {15'd0, busy}, 16'd1);
    wait_done();
    // R3 abort clears count
    for (int i = 0; i < 3; i++) wpulse(1, 0);
    cmd_abort = 1'b1; cyc(); cmd_abort = 1'b0;
    wpulse(1, 0);
    chk(!busy, "R3 abort", {15'd0, busy}, 16'd0);
    for (int i = 0; i < 3; i++) wpulse(1, 0);
    chk(busy, "R3 restart", {15'd0, busy}, 16'd1);
    // R11 pulses during busy ignored
    wpulse(0, 0); wpulse(0, 0);
    wait_done();
    for (int i = 0; i < 2; i++) wpulse(0, 0);
    chk(!busy, "R11 busy pulses ignored", {15'd0, busy}, 16'd0);
    for (int i = 0; i < 2; i++) wpulse(0, 0);
    chk(busy, "R11 full sequence", {15'd0, busy}, 16'd1);
    wait_done();
    // R1 one-sided strobe not counted
    for (int i = 0; i < 3; i++) wpulse(1, 0);
    wpulse(1, 0, 1);
    chk(!busy, "R1 one-sided strobe", {15'd0, busy}, 16'd0);
    wpulse(1, 0);
    chk(busy, "R1 combined strobe", {15'd0, busy}, 16'd1);
    rd(2);
    wait_done();
    idle(3);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule